// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Pipeline

This block is the data-hazard core of a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory and writeback. Decoded instructions arrive on a valid/ready port and enter the fetch/decode register. The block holds a register file and the stage registers. For each operand of the instruction in execute, it picks the newest copy of the value from the execute/memory register, from the memory/writeback register or from the value read at decode. A memory stage reads load data from an external memory that answers in the same cycle. Results leave on a writeback port.

A consumer three instructions behind its producer gets no bypass path. The register file passes a write through to a read of the same register in the same cycle. Load data never bypasses from the execute/memory register. When an instruction needs the register loaded by the instruction just ahead of it, the block holds fetch and decode for one cycle and sends an empty slot into execute. The consumer then takes the loaded value from the memory/writeback register.

Top module: `hz_pipe`

## Requirements
- R1: After reset `in_ready_o` is 1, `wb_valid_o` is 0, and every register reads as zero.
- R2: `in_op_i` selects the operation: 0 writes rs1+rs2, 1 writes rs1-rs2, 2 writes rs1+imm, 3 is a load that writes the memory word at address rs1+imm (`mem_addr_o`, answered on `mem_rdata_i`). Each result destined for a nonzero register leaves on the writeback port once, in program order.
- R3: A consumer directly behind an arithmetic producer of the same register gets the producer's result from the execute/memory register, with no stall.
- R4: A consumer two instructions behind its producer gets the value from the memory/writeback register, with no stall.
- R5: A consumer three instructions behind its producer reads the value through the register file, which returns a same-cycle write to the read of that register.
- R6: When both the execute/memory and memory/writeback registers hold results for the consumer's source register, the newer execute/memory result is used.
- R7: An instruction whose rs1, or rs2 for operations 0 and 1, names the nonzero destination of a load directly ahead of it stalls exactly one cycle. `in_ready_o` is low for the cycle after that instruction is accepted, and fetch/decode holds its contents. The consumer then receives the loaded data. Load data is never taken from the execute/memory register.
- R8: No stall occurs when the instruction behind a load does not read the loaded register, including when only the unused rs2 field of operations 2 and 3 matches.
- R9: The inserted empty slot behaves as a no-op: it produces no writeback and changes no register.
- R10: Register 0 always reads zero. Writes to it are discarded, it is never a bypass source, and a load to it never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A decoded instruction is presented |
| in_op_i | input | 2 | Operation code (see R2) |
| in_rd_i | input | AW | Destination register |
| in_rs1_i | input | AW | First source register |
| in_rs2_i | input | AW | Second source register |
| in_imm_i | input | XLEN | Immediate operand |
| in_ready_o | output | 1 | Instruction accepted at the next edge when high |
| mem_addr_o | output | XLEN | Address of the load in the memory stage |
| mem_rdata_i | input | XLEN | Memory data for `mem_addr_o`, same cycle |
| wb_valid_o | output | 1 | A result is being written back |
| wb_rd_o | output | AW | Register written back |
| wb_data_o | output | XLEN | Value written back |

## Verification
The assertions assume the memory answers `mem_rdata_i` combinationally from `mem_addr_o`. They also assume register indices stay below the register count. The bench keeps both by modelling the memory as a fixed function of the address and drawing indices from a narrow window. The interlock properties assume the only producer that cannot bypass is a load one slot ahead, so the stimulus sends back-to-back load chains and idle gaps that break adjacency. Programs mix directed hazard distances with random sequences over eight registers, so every bypass distance, both operands and register 0 are hit often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_ADDI = 2'd2,
    OP_LOAD = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_MEMWB = 2'd1,
    SRC_EXMEM = 2'd2
  } fwd_e;

  function automatic logic reads_rs2(op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/hz_regfile.sv
module hz_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             waddr_i,
  input  logic [XLEN-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]    raddr_i,
  output logic [NRD-1:0][XLEN-1:0]  rdata_o
);

  logic [XLEN-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // write-before-read: same-cycle write is visible to the read port
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr_i[p] == '0)
        rdata_o[p] = '0;
      else if (we_i && (waddr_i == raddr_i[p]))
        rdata_o[p] = wdata_i;
      else
        rdata_o[p] = regs_q[raddr_i[p]];
    end
  end

endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import fwd_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic [AW-1:0] src_i,
  input  logic          exmem_wr_i,
  input  logic          exmem_load_i,
  input  logic [AW-1:0] exmem_rd_i,
  input  logic          memwb_wr_i,
  input  logic [AW-1:0] memwb_rd_i,
  output fwd_e          sel_o
);

  logic hit_exmem, hit_memwb;

  // load data is not yet available in EX/MEM
  assign hit_exmem = exmem_wr_i && !exmem_load_i && (exmem_rd_i == src_i);
  assign hit_memwb = memwb_wr_i && (memwb_rd_i == src_i);

  always_comb begin
    sel_o = SRC_RF;
    if (src_i != '0) begin
      if (hit_exmem)      sel_o = SRC_EXMEM;
      else if (hit_memwb) sel_o = SRC_MEMWB;
    end
  end

endmodule

// File: rtl/hz_load_interlock.sv
module hz_load_interlock
  import fwd_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_rd_i,
  input  logic          dep_valid_i,
  input  op_e           dep_op_i,
  input  logic [AW-1:0] dep_rs1_i,
  input  logic [AW-1:0] dep_rs2_i,
  output logic          stall_o
);

  logic use1, use2;

  assign use1    = (dep_rs1_i == ld_rd_i);
  assign use2    = reads_rs2(dep_op_i) && (dep_rs2_i == ld_rd_i);
  assign stall_o = ld_valid_i && (ld_rd_i != '0) && dep_valid_i && (use1 || use2);

endmodule

// File: rtl/hz_pipe.sv
module hz_pipe
  import fwd_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [1:0]      in_op_i,
  input  logic [AW-1:0]   in_rd_i,
  input  logic [AW-1:0]   in_rs1_i,
  input  logic [AW-1:0]   in_rs2_i,
  input  logic [XLEN-1:0] in_imm_i,
  output logic            in_ready_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            wb_valid_o,
  output logic [AW-1:0]   wb_rd_o,
  output logic [XLEN-1:0] wb_data_o
);

  localparam int NSRC = 2;

  logic stall;

  // IF/ID
  logic            ifid_valid;
  op_e             ifid_op;
  logic [AW-1:0]   ifid_rd, ifid_rs1, ifid_rs2;
  logic [XLEN-1:0] ifid_imm;

  // ID/EX
  logic                       idex_valid, idex_we, idex_load;
  op_e                        idex_op;
  logic [AW-1:0]              idex_rd;
  logic [NSRC-1:0][AW-1:0]    idex_rs;
  logic [NSRC-1:0][XLEN-1:0]  idex_rv;
  logic [XLEN-1:0]            idex_imm;

  // EX/MEM
  logic            exmem_valid, exmem_we, exmem_load;
  logic [AW-1:0]   exmem_rd;
  logic [XLEN-1:0] exmem_res;

  // MEM/WB
  logic            memwb_valid, memwb_we;
  logic [AW-1:0]   memwb_rd;
  logic [XLEN-1:0] memwb_data;

  logic [NSRC-1:0][AW-1:0]   rf_raddr;
  logic [NSRC-1:0][XLEN-1:0] rf_rdata;
  logic                      rf_we;
  fwd_e                      fwd_sel [NSRC];
  logic [NSRC-1:0][XLEN-1:0] opnd;
  logic [XLEN-1:0]           alu_res;
  logic [XLEN-1:0]           mem_val;

  // ---------------- fetch / decode ----------------
  assign in_ready_o = !stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifid_valid <= 1'b0;
      ifid_op    <= OP_ADD;
      ifid_rd    <= '0;
      ifid_rs1   <= '0;
      ifid_rs2   <= '0;
      ifid_imm   <= '0;
    end else if (!stall) begin
      ifid_valid <= in_valid_i;
      ifid_op    <= op_e'(in_op_i);
      ifid_rd    <= in_rd_i;
      ifid_rs1   <= in_rs1_i;
      ifid_rs2   <= in_rs2_i;
      ifid_imm   <= in_imm_i;
    end
  end

  assign rf_raddr[0] = ifid_rs1;
  assign rf_raddr[1] = ifid_rs2;
  assign rf_we       = memwb_valid && memwb_we;

  hz_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(NSRC)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (memwb_rd),
    .wdata_i (memwb_data),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  hz_load_interlock #(.NREGS(NREGS)) u_ilk (
    .ld_valid_i  (idex_valid && idex_load),
    .ld_rd_i     (idex_rd),
    .dep_valid_i (ifid_valid),
    .dep_op_i    (ifid_op),
    .dep_rs1_i   (ifid_rs1),
    .dep_rs2_i   (ifid_rs2),
    .stall_o     (stall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idex_valid <= 1'b0;
      idex_we    <= 1'b0;
      idex_load  <= 1'b0;
      idex_op    <= OP_ADD;
      idex_rd    <= '0;
      idex_rs    <= '0;
      idex_rv    <= '0;
      idex_imm   <= '0;
    end else if (stall) begin
      // bubble: control cleared, writes nothing
      idex_valid <= 1'b0;
      idex_we    <= 1'b0;
      idex_load  <= 1'b0;
    end else begin
      idex_valid <= ifid_valid;
      idex_we    <= ifid_valid;
      idex_load  <= ifid_valid && (ifid_op == OP_LOAD);
      idex_op    <= ifid_op;
      idex_rd    <= ifid_rd;
      idex_rs    <= rf_raddr;
      idex_rv    <= rf_rdata;
      idex_imm   <= ifid_imm;
    end
  end

  // ---------------- execute ----------------
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_fwd_sel #(.NREGS(NREGS)) u_fwd (
      .src_i        (idex_rs[g]),
      .exmem_wr_i   (exmem_valid && exmem_we),
      .exmem_load_i (exmem_load),
      .exmem_rd_i   (exmem_rd),
      .memwb_wr_i   (memwb_valid && memwb_we),
      .memwb_rd_i   (memwb_rd),
      .sel_o        (fwd_sel[g])
    );

    always_comb begin
      unique case (fwd_sel[g])
        SRC_EXMEM: opnd[g] = exmem_res;
        SRC_MEMWB: opnd[g] = memwb_data;
        default:   opnd[g] = idex_rv[g];
      endcase
    end
  end

  always_comb begin
    unique case (idex_op)
      OP_ADD:  alu_res = opnd[0] + opnd[1];
      OP_SUB:  alu_res = opnd[0] - opnd[1];
      default: alu_res = opnd[0] + idex_imm;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exmem_valid <= 1'b0;
      exmem_we    <= 1'b0;
      exmem_load  <= 1'b0;
      exmem_rd    <= '0;
      exmem_res   <= '0;
    end else begin
      exmem_valid <= idex_valid;
      exmem_we    <= idex_we;
      exmem_load  <= idex_load;
      exmem_rd    <= idex_rd;
      exmem_res   <= alu_res;
    end
  end

  // ---------------- memory ----------------
  assign mem_addr_o = exmem_res;
  assign mem_val    = exmem_load ? mem_rdata_i : exmem_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      memwb_valid <= 1'b0;
      memwb_we    <= 1'b0;
      memwb_rd    <= '0;
      memwb_data  <= '0;
    end else begin
      memwb_valid <= exmem_valid;
      memwb_we    <= exmem_we;
      memwb_rd    <= exmem_rd;
      memwb_data  <= mem_val;
    end
  end

  // ---------------- writeback ----------------
  assign wb_valid_o = memwb_valid && memwb_we && (memwb_rd != '0);
  assign wb_rd_o    = memwb_rd;
  assign wb_data_o  = memwb_data;

endmodule

// File: rtl/hz_pipe_checker.sv
module hz_pipe_checker
  import fwd_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stall_i,
  input logic          ifid_valid_i,
  input op_e           ifid_op_i,
  input logic [AW-1:0] ifid_rs1_i,
  input logic [AW-1:0] ifid_rs2_i,
  input logic          idex_valid_i,
  input logic          idex_load_i,
  input op_e           idex_op_i,
  input logic [AW-1:0] idex_rd_i,
  input logic [AW-1:0] idex_rs1_i,
  input logic [AW-1:0] idex_rs2_i,
  input logic          exmem_valid_i,
  input logic          exmem_load_i,
  input logic [AW-1:0] exmem_rd_i,
  input logic          memwb_valid_i,
  input logic [AW-1:0] memwb_rd_i,
  input fwd_e          sel_a_i,
  input fwd_e          sel_b_i
);

  // R7: interlock lasts one cycle
  p_stall_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !stall_i);

  // R7: fetch/decode holds during the stall
  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ifid_valid_i && $stable(ifid_op_i) && $stable(ifid_rs1_i) && $stable(ifid_rs2_i));

  // R7: a load in EX/MEM never has a consumer in EX
  p_load_not_exmem_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exmem_valid_i && exmem_load_i && exmem_rd_i != '0 && idex_valid_i) |->
      (idex_rs1_i != exmem_rd_i) && (!reads_rs2(idex_op_i) || idex_rs2_i != exmem_rd_i));

  // R9: the slot behind a stall is empty
  p_stall_bubble_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !idex_valid_i);

  // R6: newer producer wins
  p_prio_exmem_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exmem_valid_i && !exmem_load_i && idex_rs1_i != '0 && exmem_rd_i == idex_rs1_i) |->
      sel_a_i == SRC_EXMEM);

  // R4: older producer used when newer one does not match
  p_memwb_fwd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (memwb_valid_i && idex_rs2_i != '0 && memwb_rd_i == idex_rs2_i &&
     !(exmem_valid_i && exmem_rd_i == idex_rs2_i)) |-> sel_b_i == SRC_MEMWB);

  // R10: register 0 is never bypassed
  p_r0_no_fwd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idex_rs1_i == '0) |-> sel_a_i == SRC_RF);

  // R10: a load to register 0 never stalls
  p_r0_no_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idex_load_i && idex_rd_i == '0) |-> !stall_i);

endmodule

bind hz_pipe hz_pipe_checker #(.NREGS(NREGS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stall_i       (stall),
  .ifid_valid_i  (ifid_valid),
  .ifid_op_i     (ifid_op),
  .ifid_rs1_i    (ifid_rs1),
  .ifid_rs2_i    (ifid_rs2),
  .idex_valid_i  (idex_valid),
  .idex_load_i   (idex_load),
  .idex_op_i     (idex_op),
  .idex_rd_i     (idex_rd),
  .idex_rs1_i    (idex_rs[0]),
  .idex_rs2_i    (idex_rs[1]),
  .exmem_valid_i (exmem_valid),
  .exmem_load_i  (exmem_load),
  .exmem_rd_i    (exmem_rd),
  .memwb_valid_i (memwb_valid),
  .memwb_rd_i    (memwb_rd),
  .sel_a_i       (fwd_sel[0]),
  .sel_b_i       (fwd_sel[1])
);

// File: tb/hz_pipe_tb.sv
module hz_pipe_tb;
  import fwd_pkg::*;

  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int AW    = $clog2(NREGS);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid;
  logic [1:0]      in_op;
  logic [AW-1:0]   in_rd, in_rs1, in_rs2;
  logic [XLEN-1:0] in_imm;
  logic            in_ready;
  logic [XLEN-1:0] mem_addr, mem_rdata;
  logic            wb_valid;
  logic [AW-1:0]   wb_rd;
  logic [XLEN-1:0] wb_data;

  always #5 clk = ~clk;

  function automatic logic [XLEN-1:0] mem_f(logic [XLEN-1:0] a);
    return (a * 32'h0000_9e37) ^ 32'h5a5a_1234;
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  hz_pipe #(.XLEN(XLEN), .NREGS(NREGS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_op_i(in_op), .in_rd_i(in_rd),
    .in_rs1_i(in_rs1), .in_rs2_i(in_rs2), .in_imm_i(in_imm),
    .in_ready_o(in_ready),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .wb_valid_o(wb_valid), .wb_rd_o(wb_rd), .wb_data_o(wb_data)
  );

  typedef struct {
    logic [AW-1:0]   rd;
    logic [XLEN-1:0] data;
    string           tag;
  } wb_item_t;

  wb_item_t        sb_q[$];
  int              checks = 0;
  int              errors = 0;
  logic [XLEN-1:0] ref_rf [NREGS];
  logic            pend_stall;
  logic            prev_ld;
  logic [AW-1:0]   prev_rd;

  task automatic check_val(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(op_e op, int rd, int rs1, int rs2, logic [XLEN-1:0] imm, string tag);
    logic [XLEN-1:0] a, b, res;
    logic            uses2;
    int              w;
    string           stag;
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_rd    = AW'(rd);
    in_rs1   = AW'(rs1);
    in_rs2   = AW'(rs2);
    in_imm   = imm;
    w = 0;
    while (!in_ready && w < 4) begin
      @(negedge clk);
      w++;
    end
    stag = pend_stall ? "R7" : "R8";
    check_val(stag, "stall cycles", XLEN'(w), pend_stall ? 1 : 0);
    @(posedge clk);
    a = (rs1 == 0) ? '0 : ref_rf[rs1];
    b = (rs2 == 0) ? '0 : ref_rf[rs2];
    unique case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_ADDI: res = a + imm;
      default: res = mem_f(a + imm);
    endcase
    uses2      = (op == OP_ADD) || (op == OP_SUB);
    pend_stall = prev_ld && (prev_rd != '0) &&
                 ((AW'(rs1) == prev_rd) || (uses2 && AW'(rs2) == prev_rd));
    prev_ld    = (op == OP_LOAD);
    prev_rd    = AW'(rd);
    if (rd != 0) begin
      ref_rf[rd] = res;
      sb_q.push_back('{AW'(rd), res, tag});
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    if (in_ready) prev_ld = 1'b0;
    pend_stall = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      if (sb_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9 unexpected writeback actual=%h expected=none", wb_data);
      end else begin
        wb_item_t it;
        it = sb_q.pop_front();
        check_val(it.tag, "wb rd", XLEN'(wb_rd), XLEN'(it.rd));
        check_val(it.tag, "wb data", wb_data, it.data);
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREGS; i++) ref_rf[i] = '0;
    pend_stall = 1'b0;
    prev_ld    = 1'b0;
    prev_rd    = '0;
    in_valid   = 1'b0;
    in_op      = '0;
    in_rd      = '0;
    in_rs1     = '0;
    in_rs2     = '0;
    in_imm     = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R1", "ready after reset", XLEN'(in_ready), 1);
    check_val("R1", "wb idle after reset", XLEN'(wb_valid), 0);

    // R1: registers read zero
    issue(OP_ADD, 24, 24, 25, 0, "R1");
    issue(OP_ADDI, 1, 0, 0, 32'h11, "R2");
    issue(OP_ADDI, 2, 0, 0, 32'h22, "R2");
    idle(); idle(); idle();

    // R3: distance one
    issue(OP_ADDI, 3, 0, 0, 100, "R3");
    issue(OP_ADD, 4, 3, 3, 0, "R3");
    issue(OP_SUB, 26, 1, 4, 0, "R3");
    idle(); idle(); idle();

    // R4: distance two
    issue(OP_ADDI, 5, 0, 0, 7, "R4");
    issue(OP_ADDI, 9, 0, 0, 2, "R2");
    issue(OP_SUB, 6, 5, 9, 0, "R4");
    idle(); idle(); idle();

    // R5: distance three through the register file
    issue(OP_ADDI, 7, 0, 0, 9, "R5");
    issue(OP_ADDI, 10, 0, 0, 3, "R2");
    issue(OP_ADDI, 11, 0, 0, 4, "R2");
    issue(OP_ADD, 8, 0, 7, 0, "R5");
    idle(); idle(); idle();

    // R6: both stages target the same register
    issue(OP_ADDI, 12, 0, 0, 1, "R6");
    issue(OP_ADDI, 12, 0, 0, 2, "R6");
    issue(OP_ADD, 13, 12, 12, 0, "R6");
    idle(); idle(); idle();

    // R7: load-use, both operands, and load-to-load chain
    issue(OP_LOAD, 14, 1, 0, 4, "R7");
    issue(OP_ADD, 15, 14, 1, 0, "R7");
    issue(OP_LOAD, 16, 2, 0, 8, "R7");
    issue(OP_SUB, 17, 1, 16, 0, "R7");
    issue(OP_LOAD, 20, 1, 0, 0, "R7");
    issue(OP_LOAD, 21, 20, 0, 0, "R7");
    issue(OP_ADD, 22, 21, 21, 0, "R7");
    idle(); idle(); idle();

    // R8: no stall for unrelated or unused-field matches
    issue(OP_LOAD, 16, 2, 0, 12, "R8");
    issue(OP_ADDI, 17, 3, 16, 5, "R8");
    issue(OP_LOAD, 18, 1, 0, 2, "R8");
    issue(OP_LOAD, 19, 2, 18, 0, "R8");
    issue(OP_LOAD, 22, 1, 0, 6, "R8");
    idle();
    issue(OP_ADD, 23, 22, 22, 0, "R8");
    idle(); idle(); idle();

    // R9: stall overlapping an idle cycle
    issue(OP_LOAD, 25, 2, 0, 1, "R9");
    issue(OP_ADD, 27, 25, 0, 0, "R9");
    idle();
    issue(OP_ADD, 28, 27, 25, 0, "R9");
    idle(); idle(); idle();

    // R10: register 0
    issue(OP_ADDI, 0, 1, 0, 55, "R10");
    issue(OP_ADD, 29, 0, 1, 0, "R10");
    issue(OP_LOAD, 0, 1, 0, 3, "R10");
    issue(OP_ADD, 30, 0, 0, 0, "R10");
    idle(); idle(); idle();

    // random mix over a narrow register window
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 5) == 0) idle();
      issue(op_e'($urandom_range(0, 3)), $urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 7), XLEN'($urandom_range(0, 255)), "R2");
    end

    repeat (8) idle();
    check_val("R9", "pending writebacks", XLEN'(sb_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule